// File: doc/BRIEF.md
# Instruction Start Tag Unit

This block sits at one byte position of a chain that marks where instructions begin in a fetched line. An earlier position that has found its instruction's length passes a one-cycle tag pulse to the position where the next instruction starts. Each position therefore receives one tag line from each of the preceding positions, at distances 1 to N_DIST. A separate inject input starts the chain, for example after a branch. The decoder for this position supplies a one-hot length and an instruction-ready flag. The crossbar toward the output buffers supplies a ready flag.

When a tag is present and both ready inputs are high, the unit fires in that same cycle. It drives a tag pulse on the output line chosen by its length and squashes the positions it covers. It also raises a forward strobe that hands the instruction to one of N_ROWS output-buffer rows, taken in round-robin order. If readiness is missing when the tag pulse arrives, an internal flag holds the tag until both ready inputs are high. Passing the tag on clears the flag, so no acknowledge signal exists. The forward strobe follows valid/ready rules with the crossbar ready as back-pressure: `fwd_valid` is never raised while `xbar_rdy` is low. The tag is held, without any limit on how long, until the crossbar is ready.

Top module: `tag_pos_unit`

## Requirements
- R1: After reset, `tag_out`, `squash_out` and `fwd_valid` are all zero, `proto_err` is 0 and `fwd_row` is 0. No tag is present until a tag or inject pulse arrives.
- R2: When the unit fires, `tag_out` equals `len_onehot`. Bit k of both vectors means distance k+1. At most one `tag_out` bit is high in any cycle.
- R3: A tag that arrives on any `tag_in` bit makes the unit fire in the same cycle when `inst_rdy` and `xbar_rdy` are both high in that cycle.
- R4: A tag that arrives while `inst_rdy` or `xbar_rdy` is low is held. The unit fires in the first later cycle in which both inputs are high.
- R5: Firing consumes the held tag. After a firing the outputs stay zero until a new tag arrives, so each tag gives exactly one cycle of `tag_out`, `squash_out` and `fwd_valid`.
- R6: When the unit fires with length L, `squash_out[j]` (distance j+1) is high exactly for j+1 < L. With L=1 no squash bit is high.
- R7: `fwd_valid` is high exactly in the cycles in which the unit fires. `fwd_len` then carries `len_onehot`. `fwd_valid` is never high while `xbar_rdy` is low.
- R8: `fwd_row` names the buffer row of the current forward. It advances by one after each forward and wraps from N_ROWS-1 to 0.
- R9: A tag pulse that arrives while a tag is already held sets `proto_err` in the next cycle. `proto_err` stays set until reset.
- R10: A pulse on `tag_inject` acts exactly like an incoming tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tag_in | input | N_DIST | Tag pulses from the earlier positions; bit k is distance k+1 |
| tag_inject | input | 1 | Starts the chain at this position |
| len_onehot | input | N_DIST | One-hot instruction length from the decoder; bit k is length k+1 |
| inst_rdy | input | 1 | Length and instruction bytes are valid |
| xbar_rdy | input | 1 | Crossbar can accept a forward (back-pressure) |
| tag_out | output | N_DIST | Tag pulse toward the next instruction start |
| squash_out | output | N_DIST-1 | Discard strobe for the positions covered by this instruction |
| fwd_valid | output | 1 | Forward strobe to the output buffer |
| fwd_row | output | $clog2(N_ROWS) | Buffer row that receives this forward |
| fwd_len | output | N_DIST | Length of the forwarded instruction, one-hot |
| proto_err | output | 1 | Sticky flag: a tag arrived while one was held |

## Verification
The bench builds the block with N_DIST=7 and N_ROWS=4. These values let it drive tags from every distance, including the farthest. They also let it check lengths from 1, where nothing is squashed, up to 7, where six positions are squashed. More than four forwards are issued, so the row index wraps. Both readiness inputs are stalled separately for several cycles to exercise the held tag, and an overlapping tag is sent to trip the sticky error.

// File: rtl/tag_pos_pkg.sv
package tag_pos_pkg;
  localparam int DEF_DIST = 7;
  localparam int DEF_ROWS = 4;
endpackage

// File: rtl/tag_hold.sv
module tag_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic tag_now,
  input  logic fire,
  output logic held,
  output logic err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held <= 1'b0;
      err  <= 1'b0;
    end else begin
      if (fire)         held <= 1'b0;
      else if (tag_now) held <= 1'b1;
      if (tag_now && held) err <= 1'b1;
    end
  end

  AST_FIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !held); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R9
  AST_ERR_ON_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_now && held) |=> err); // R9
endmodule

// File: rtl/tag_route.sv
module tag_route #(
  parameter int N_DIST = tag_pos_pkg::DEF_DIST
) (
  input  logic              fire,
  input  logic [N_DIST-1:0] len_onehot,
  output logic [N_DIST-1:0] tag_out,
  output logic [N_DIST-2:0] squash_out
);
  assign tag_out = fire ? len_onehot : '0;

  for (genvar j = 0; j < N_DIST - 1; j++) begin : g_sq
    assign squash_out[j] = fire & (|len_onehot[N_DIST-1:j+1]);
  end

  always_comb begin
    if (fire) AST_ROUTE_ONEHOT: assert ($onehot0(tag_out)); // R2
  end
endmodule

// File: rtl/row_rotor.sv
module row_rotor #(
  parameter int N_ROWS = tag_pos_pkg::DEF_ROWS,
  localparam int ROW_W = (N_ROWS > 1) ? $clog2(N_ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [ROW_W-1:0] row
);
  localparam logic [ROW_W-1:0] LAST = ROW_W'(N_ROWS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)    row <= '0;
    else if (adv)  row <= (row == LAST) ? '0 : row + 1'b1;
  end

  AST_ROW_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && row != LAST) |=> row == $past(row) + 1'b1); // R8
  AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && row == LAST) |=> row == '0); // R8
  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(row)); // R8
endmodule

// File: rtl/tag_pos_unit.sv
module tag_pos_unit #(
  parameter int N_DIST = tag_pos_pkg::DEF_DIST,
  parameter int N_ROWS = tag_pos_pkg::DEF_ROWS,
  localparam int ROW_W = (N_ROWS > 1) ? $clog2(N_ROWS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_DIST-1:0] tag_in,
  input  logic              tag_inject,
  input  logic [N_DIST-1:0] len_onehot,
  input  logic              inst_rdy,
  input  logic              xbar_rdy,
  output logic [N_DIST-1:0] tag_out,
  output logic [N_DIST-2:0] squash_out,
  output logic              fwd_valid,
  output logic [ROW_W-1:0]  fwd_row,
  output logic [N_DIST-1:0] fwd_len,
  output logic              proto_err
);
  logic tag_now, held, fire;

  assign tag_now = (|tag_in) | tag_inject;
  assign fire    = (held | tag_now) & inst_rdy & xbar_rdy;

  tag_hold u_hold (
    .clk(clk), .rst_n(rst_n), .tag_now(tag_now), .fire(fire),
    .held(held), .err(proto_err)
  );

  tag_route #(.N_DIST(N_DIST)) u_route (
    .fire(fire), .len_onehot(len_onehot),
    .tag_out(tag_out), .squash_out(squash_out)
  );

  row_rotor #(.N_ROWS(N_ROWS)) u_rows (
    .clk(clk), .rst_n(rst_n), .adv(fire), .row(fwd_row)
  );

  assign fwd_valid = fire;
  assign fwd_len   = fire ? len_onehot : '0;

  AST_NO_FIRE_UNREADY: assert property (@(posedge clk) disable iff (!rst_n)
    (|tag_out) |-> (inst_rdy && xbar_rdy)); // R3
  AST_FWD_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> xbar_rdy); // R7
  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    ((held || tag_now) && !(inst_rdy && xbar_rdy)) |=> held); // R4
  AST_TAG_MATCHES_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (|tag_out) |-> fwd_valid); // R7
endmodule

// File: tb/tag_pos_unit_tb_top.sv
module tag_pos_unit_tb_top;
  localparam int ND = 7;
  localparam int NR = 4;
  localparam int RW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ND-1:0] tag_in = '0;
  logic tag_inject = 1'b0;
  logic [ND-1:0] len_onehot = '0;
  logic inst_rdy = 1'b0, xbar_rdy = 1'b0;
  logic [ND-1:0] tag_out, fwd_len;
  logic [ND-2:0] squash_out;
  logic fwd_valid, proto_err;
  logic [RW-1:0] fwd_row;

  always #10 clk = ~clk;

  tag_pos_unit #(.N_DIST(ND), .N_ROWS(NR)) dut_i (
    .clk(clk), .rst_n(rst_n), .tag_in(tag_in), .tag_inject(tag_inject),
    .len_onehot(len_onehot), .inst_rdy(inst_rdy), .xbar_rdy(xbar_rdy),
    .tag_out(tag_out), .squash_out(squash_out), .fwd_valid(fwd_valid),
    .fwd_row(fwd_row), .fwd_len(fwd_len), .proto_err(proto_err)
  );

  typedef struct packed {
    logic [31:0]   cyc;
    logic [ND-1:0] tag;
    logic [ND-2:0] sq;
    logic [RW-1:0] row;
  } exp_t;

  exp_t sb[$];
  int checks = 0, errors = 0;
  int cyc = 0;
  logic m_held = 1'b0;
  int m_row = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare produced forwards against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (sb.size() > 0 && sb[0].cyc == 32'(cyc)) begin
        exp_t e;
        e = sb.pop_front();
        if (!fwd_valid || tag_out !== e.tag || fwd_len !== e.tag ||
            squash_out !== e.sq || fwd_row !== e.row) begin
          errors++;
          $display("FAIL R2/R3/R6/R7/R8 cyc %0d: valid=%b tag=%b sq=%b row=%0d len=%b exp tag=%b sq=%b row=%0d",
                   cyc, fwd_valid, tag_out, squash_out, fwd_row, fwd_len, e.tag, e.sq, e.row);
        end
      end else if (fwd_valid || tag_out != '0 || squash_out != '0) begin
        errors++;
        $display("FAIL R5 cyc %0d: spurious valid=%b tag=%b sq=%b expected none",
                 cyc, fwd_valid, tag_out, squash_out);
      end
    end
  end

  task automatic check_eq(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and predicts the outcome
  task automatic step(input logic [ND-1:0] t, input logic inj, input int L,
                      input logic ir, input logic xr);
    logic now, fire;
    exp_t e;
    @(posedge clk); #2;
    tag_in = t; tag_inject = inj; inst_rdy = ir; xbar_rdy = xr;
    len_onehot = (L > 0) ? ND'(1) << (L - 1) : '0;
    now  = (t != '0) || inj;
    fire = (m_held || now) && ir && xr;
    if (fire) begin
      e.cyc = 32'(cyc);
      e.tag = len_onehot;
      for (int j = 0; j < ND - 1; j++) e.sq[j] = (j + 1 < L);
      e.row = RW'(m_row);
      sb.push_back(e);
      m_row = (m_row + 1) % NR;
    end
    if (fire) m_held = 1'b0;
    else if (now) m_held = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step('0, 1'b0, 0, 1'b1, 1'b1);
  endtask

  task automatic do_reset();
    @(posedge clk); #2;
    rst_n = 1'b0; tag_in = '0; tag_inject = 1'b0; inst_rdy = 1'b0; xbar_rdy = 1'b0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    m_held = 1'b0; m_row = 0; sb.delete();
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1 reset state
    check_eq("R1 tag_out", int'(tag_out), 0);
    check_eq("R1 fwd_valid", int'(fwd_valid), 0);
    check_eq("R1 proto_err", int'(proto_err), 0);
    check_eq("R1 fwd_row", int'(fwd_row), 0);
    idle(2); // R1: ready with no tag must not fire

    // R3/R2/R6: same-cycle pass, various distances and lengths
    step(7'b0000001, 1'b0, 3, 1'b1, 1'b1);
    step(7'b1000000, 1'b0, 7, 1'b1, 1'b1);
    step(7'b0001000, 1'b0, 1, 1'b1, 1'b1);   // R6 no squash
    idle(1);
    // R10 inject
    step('0, 1'b1, 2, 1'b1, 1'b1);
    idle(1);

    // R4 instruction not ready: hold then fire
    step(7'b0000100, 1'b0, 5, 1'b0, 1'b1);
    step('0, 1'b0, 5, 1'b0, 1'b1);
    step('0, 1'b0, 5, 1'b0, 1'b1);
    step('0, 1'b0, 5, 1'b1, 1'b1);
    idle(2);                                // R5 no repeat
    // R4/R7 crossbar back-pressure
    step(7'b0100000, 1'b0, 4, 1'b1, 1'b0);
    step('0, 1'b0, 4, 1'b1, 1'b0);
    step('0, 1'b0, 4, 1'b1, 1'b0);
    step('0, 1'b0, 6, 1'b1, 1'b1);
    idle(1);
    @(negedge clk);
    check_eq("R8 row after wrap", int'(fwd_row), m_row);
    check_eq("R9 no error yet", int'(proto_err), 0);

    // R9 overlap sets sticky error
    step(7'b0000010, 1'b0, 2, 1'b0, 1'b0);
    step(7'b0000001, 1'b0, 2, 1'b0, 1'b0);
    step('0, 1'b0, 2, 1'b1, 1'b1);
    @(negedge clk);
    check_eq("R9 error set", int'(proto_err), 1);
    idle(3);
    @(negedge clk);
    check_eq("R9 error sticky", int'(proto_err), 1);

    do_reset();
    @(negedge clk);
    check_eq("R1 error cleared by reset", int'(proto_err), 0);
    check_eq("R1 row cleared by reset", int'(fwd_row), 0);
    step(7'b0010000, 1'b0, 7, 1'b1, 1'b1);
    idle(2);
    check_eq("R3 scoreboard drained", sb.size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule